// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Receive Controller

This block serves one bulk OUT endpoint on the device side of a USB link. An upstream protocol engine has already decoded the packet stream. It delivers each data packet to this block as a start strobe, a run of byte strobes and an end strobe, with a CRC-error qualifier on the end strobe. The block holds one packet-sized receive buffer. A packet that arrives while the buffer is free is stored and answered with ACK. A packet that arrives while the buffer still holds unread data is dropped and answered with NAK, so the host retries it later.

The local CPU reads the stored bytes through a byte-addressed read port. It then frees the buffer with a release strobe, and the host's next retry is accepted. Two sticky event flags record when a full buffer refused a packet and when a packet was stored. Each flag has an enable bit. A routing field steers each flag either to a shared interrupt line or to one of two dedicated lines. A dedicated line tells software the event source without decoding any status.

Top module: `usb_oep_rx`

## Requirements
- R1: After reset both event flags are 0, the buffer is empty, both enables are 0, both routing fields select the shared line, all interrupt lines are low and no handshake is presented.
- R2: A packet of exactly PKT_BYTES bytes without a CRC error that starts while the buffer is empty is stored. The buffer-full bit (status bit 2) sets, the done flag (status bit 1) sets, and a one-cycle handshake strobe carries code ACK = 2'b01. The strobe appears HS_LATENCY clock edges after the edge that samples the end strobe.
- R3: A packet of correct length without a CRC error that starts while the buffer is full is discarded and leaves the buffer contents unchanged. It is answered with NAK = 2'b10, and it sets the full-error flag (status bit 0).
- R4: A packet with a byte count other than PKT_BYTES, or with the CRC-error qualifier set at its end, produces no handshake, sets no flag and does not mark the buffer full.
- R5: Writing register 0 clears each event flag whose data bit is 0. A data bit of 1 leaves that flag as it is. Status bit 2 is read-only.
- R6: The buffer-full bit clears only on the release strobe. After a release, the next good packet is accepted with ACK.
- R7: While the buffer is full, the read port returns the stored byte at the given index, with index 0 being the first byte received.
- R8: Register 2 holds a 2-bit route for each event: full-error at bits [1:0] and done at bits [3:2]. A route of 01 selects line A, 10 selects line B, and 00 or 11 selects the shared line.
- R9: Each interrupt line is the OR, over the events routed to it, of the event flag ANDed with its enable. Register 1 bit 0 enables full-error and bit 1 enables done.
- R10: When an event sets a flag in the same cycle that a register-0 write clears it, the flag ends up set.
- R11: The handshake code is 2'b00 whenever the strobe is low, and is ACK or NAK whenever it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Start of an OUT data packet |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | DATA_W | Payload byte |
| rx_end | input | 1 | End of data packet |
| rx_crc_err | input | 1 | CRC error qualifier, valid with rx_end |
| hs_stb | output | 1 | One-cycle handshake strobe |
| hs_code | output | 2 | Handshake code: 01 ACK, 10 NAK, 00 idle |
| buf_release | input | 1 | CPU release of the receive buffer |
| rd_addr | input | AW | Byte index into the receive buffer |
| rd_data | output | DATA_W | Stored byte at rd_addr |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 route |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq_shared | output | 1 | Shared interrupt line |
| irq_a | output | 1 | Dedicated interrupt line A |
| irq_b | output | 1 | Dedicated interrupt line B |

## Verification
Two functions can fall on the same clock edge: an event flag being set at the end of a packet, and a CPU write of 0 that clears it. The bench drives the clearing write to register 0 in exactly the cycle that carries the end strobe. It does this once for an accepted packet and once for a refused one. It then reads the status back. The flag raised by that packet must be set. The flag that was not raised must have taken the clear.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

   localparam logic [1:0] HS_NONE = 2'b00;
   localparam logic [1:0] HS_ACK  = 2'b01;
   localparam logic [1:0] HS_NAK  = 2'b10;

   localparam int NUM_EVT     = 2;
   localparam int EVT_FULLERR = 0;
   localparam int EVT_DONE    = 1;

   localparam logic [1:0] RT_SHARED = 2'b00;
   localparam logic [1:0] RT_LINE_A = 2'b01;
   localparam logic [1:0] RT_LINE_B = 2'b10;

   localparam int REG_AW = 2;
   localparam logic [REG_AW-1:0] ADDR_STAT = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_EN   = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_RT   = 2'd2;

endpackage

// File: rtl/oep_rx_seq.sv
module oep_rx_seq
   import usb_oep_pkg::*;
#(
   parameter int PKT_BYTES  = 64,
   parameter int DATA_W     = 8,
   parameter int HS_LATENCY = 2,
   parameter int AW         = $clog2(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_start,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_end,
   input  logic              rx_crc_err,
   input  logic              buf_full,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              commit,
   output logic              fullerr_evt,
   output logic              hs_stb,
   output logic [1:0]        hs_code
);

   localparam int CNT_W = $clog2(PKT_BYTES + 2);
   localparam logic [CNT_W-1:0] CNT_PKT = CNT_W'(PKT_BYTES);
   localparam logic [CNT_W-1:0] CNT_OVR = CNT_W'(PKT_BYTES + 1);

   logic             in_pkt_q;
   logic             accept_q;
   logic [CNT_W-1:0] cnt_q;
   logic             end_ok;
   logic             dec_vld;
   logic [1:0]       dec_code;

   // packet tracking: room is judged once, at the start of the packet
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         accept_q <= 1'b0;
         cnt_q    <= '0;
      end else if (rx_start) begin
         in_pkt_q <= 1'b1;
         accept_q <= !buf_full;
         cnt_q    <= '0;
      end else if (in_pkt_q && rx_end) begin
         in_pkt_q <= 1'b0;
      end else if (in_pkt_q && rx_valid && (cnt_q != CNT_OVR)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign wr_en   = in_pkt_q && rx_valid && !rx_start && !rx_end && accept_q && (cnt_q < CNT_PKT);
   assign wr_addr = cnt_q[AW-1:0];
   assign wr_data = rx_byte;

   assign end_ok      = in_pkt_q && rx_end && !rx_start && (cnt_q == CNT_PKT) && !rx_crc_err;
   assign commit      = end_ok && accept_q;
   assign fullerr_evt = end_ok && !accept_q;
   assign dec_vld     = end_ok;
   assign dec_code    = accept_q ? HS_ACK : HS_NAK;

   // handshake delay line
   generate
      if (HS_LATENCY == 1) begin : g_hs_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hs_stb  <= 1'b0;
               hs_code <= HS_NONE;
            end else begin
               hs_stb  <= dec_vld;
               hs_code <= dec_vld ? dec_code : HS_NONE;
            end
         end
      end else begin : g_hs_pipe
         logic [HS_LATENCY-1:0] vld_sr;
         logic [1:0]            code_sr [HS_LATENCY];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_sr <= '0;
               for (int i = 0; i < HS_LATENCY; i++) code_sr[i] <= HS_NONE;
            end else begin
               vld_sr     <= {vld_sr[HS_LATENCY-2:0], dec_vld};
               code_sr[0] <= dec_vld ? dec_code : HS_NONE;
               for (int i = 1; i < HS_LATENCY; i++) code_sr[i] <= code_sr[i-1];
            end
         end
         assign hs_stb  = vld_sr[HS_LATENCY-1];
         assign hs_code = code_sr[HS_LATENCY-1];
      end
   endgenerate

endmodule

// File: rtl/oep_rx_buf.sv
module oep_rx_buf #(
   parameter int PKT_BYTES = 64,
   parameter int DATA_W    = 8,
   parameter int AW        = $clog2(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              rel_stb,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              full
);

   logic [DATA_W-1:0] mem_q [PKT_BYTES];
   logic              full_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   // a commit outranks a release in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)       full_q <= 1'b0;
      else if (commit)  full_q <= 1'b1;
      else if (rel_stb) full_q <= 1'b0;
   end

   assign rd_data = mem_q[rd_addr];
   assign full    = full_q;

endmodule

// File: rtl/oep_rx_flags.sv
module oep_rx_flags
   import usb_oep_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVT-1:0]    evt_set,
   input  logic                  buf_full,
   input  logic                  reg_wr,
   input  logic [REG_AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_EVT-1:0]    flags,
   output logic [NUM_EVT-1:0]    enables,
   output logic [2*NUM_EVT-1:0]  routes,
   output logic                  irq_shared,
   output logic                  irq_a,
   output logic                  irq_b
);

   logic wr_stat;
   logic wr_en_reg;
   logic wr_rt;
   logic [NUM_EVT-1:0] to_a;
   logic [NUM_EVT-1:0] to_b;
   logic [NUM_EVT-1:0] to_sh;

   assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
   assign wr_en_reg = reg_wr && (reg_addr == ADDR_EN);
   assign wr_rt     = reg_wr && (reg_addr == ADDR_RT);

   generate
      for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
         logic       flag_r;
         logic       en_r;
         logic [1:0] rt_r;
         logic       active;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_r <= 1'b0;
               en_r   <= 1'b0;
               rt_r   <= RT_SHARED;
            end else begin
               if (evt_set[e])                     flag_r <= 1'b1;
               else if (wr_stat && !reg_wdata[e])  flag_r <= 1'b0;
               if (wr_en_reg) en_r <= reg_wdata[e];
               if (wr_rt)     rt_r <= reg_wdata[2*e +: 2];
            end
         end

         assign active          = flag_r & en_r;
         assign to_a[e]         = active && (rt_r == RT_LINE_A);
         assign to_b[e]         = active && (rt_r == RT_LINE_B);
         assign to_sh[e]        = active && (rt_r != RT_LINE_A) && (rt_r != RT_LINE_B);
         assign flags[e]        = flag_r;
         assign enables[e]      = en_r;
         assign routes[2*e +: 2] = rt_r;
      end
   endgenerate

   assign irq_a      = |to_a;
   assign irq_b      = |to_b;
   assign irq_shared = |to_sh;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_STAT: begin
            reg_rdata[NUM_EVT-1:0] = flags;
            reg_rdata[NUM_EVT]     = buf_full;
         end
         ADDR_EN:   reg_rdata[NUM_EVT-1:0]   = enables;
         ADDR_RT:   reg_rdata[2*NUM_EVT-1:0] = routes;
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/usb_oep_rx.sv
module usb_oep_rx
   import usb_oep_pkg::*;
#(
   parameter int PKT_BYTES  = 64,
   parameter int DATA_W     = 8,
   parameter int HS_LATENCY = 2,
   parameter int AW         = $clog2(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_start,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_end,
   input  logic              rx_crc_err,
   output logic              hs_stb,
   output logic [1:0]        hs_code,
   input  logic              buf_release,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_shared,
   output logic              irq_a,
   output logic              irq_b
);

   initial begin
      assert (PKT_BYTES >= 2 && (PKT_BYTES & (PKT_BYTES - 1)) == 0)
         else $fatal(1, "PKT_BYTES must be a power of two, at least 2");
      assert (AW == $clog2(PKT_BYTES))
         else $fatal(1, "AW must match PKT_BYTES");
      assert (HS_LATENCY >= 1)
         else $fatal(1, "HS_LATENCY must be at least 1");
      assert (DATA_W >= 2 * NUM_EVT)
         else $fatal(1, "DATA_W too narrow for the route register");
   end

   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              commit;
   logic              fullerr_evt;
   logic              buf_full_w;
   logic [NUM_EVT-1:0]   evt_set;
   logic [NUM_EVT-1:0]   st_flags;
   logic [NUM_EVT-1:0]   st_en;
   logic [2*NUM_EVT-1:0] st_routes;

   oep_rx_seq #(
      .PKT_BYTES (PKT_BYTES),
      .DATA_W    (DATA_W),
      .HS_LATENCY(HS_LATENCY),
      .AW        (AW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_start   (rx_start),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .rx_end     (rx_end),
      .rx_crc_err (rx_crc_err),
      .buf_full   (buf_full_w),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .commit     (commit),
      .fullerr_evt(fullerr_evt),
      .hs_stb     (hs_stb),
      .hs_code    (hs_code)
   );

   oep_rx_buf #(
      .PKT_BYTES(PKT_BYTES),
      .DATA_W   (DATA_W),
      .AW       (AW)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .commit (commit),
      .rel_stb(buf_release),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .full   (buf_full_w)
   );

   always_comb begin
      evt_set              = '0;
      evt_set[EVT_FULLERR] = fullerr_evt;
      evt_set[EVT_DONE]    = commit;
   end

   oep_rx_flags #(
      .DATA_W(DATA_W)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_set   (evt_set),
      .buf_full  (buf_full_w),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flags     (st_flags),
      .enables   (st_en),
      .routes    (st_routes),
      .irq_shared(irq_shared),
      .irq_a     (irq_a),
      .irq_b     (irq_b)
   );

endmodule

// File: rtl/oep_rx_chk.sv
module oep_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hs_stb,
   input logic [1:0] hs_code,
   input logic       buf_full,
   input logic       buf_release,
   input logic [1:0] st_flags,
   input logic [1:0] st_en,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       irq_shared,
   input logic       irq_a,
   input logic       irq_b
);

   assert_hs_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hs_stb |-> (hs_code == 2'b01 || hs_code == 2'b10));

   assert_hs_code_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_stb |-> (hs_code == 2'b00));

   assert_hs_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_stb |=> !hs_stb);

   assert_full_needs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_full) |-> $past(buf_release));

   assert_fullerr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_flags[0]) && !($past(reg_wr) && $past(reg_addr) == 2'd0 && !$past(reg_wdata[0])))
         |-> st_flags[0]);

   assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_flags[1]) && !($past(reg_wr) && $past(reg_addr) == 2'd0 && !$past(reg_wdata[1])))
         |-> st_flags[1]);

   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_flags & st_en) == 2'b00) |-> !(irq_shared || irq_a || irq_b));

endmodule

bind usb_oep_rx oep_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_stb     (hs_stb),
   .hs_code    (hs_code),
   .buf_full   (buf_full_w),
   .buf_release(buf_release),
   .st_flags   (st_flags),
   .st_en      (st_en),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .irq_shared (irq_shared),
   .irq_a      (irq_a),
   .irq_b      (irq_b)
);

// File: tb/sim_usb_oep_rx.sv
`timescale 1ns/100ps
module sim_usb_oep_rx;

   localparam int PKT    = 64;
   localparam int AW     = 6;
   localparam int HS_LAT = 2;

   // vector: {len[7:0], release_first, crc_err, exp_hs[1:0], exp_fullerr, exp_done}
   localparam int NV = 9;
   localparam logic [13:0] VEC [NV] = '{
      {8'd64, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1},
      {8'd64, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0},
      {8'd63, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
      {8'd64, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
      {8'd64, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1},
      {8'd65, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0},
      {8'd64, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},
      {8'd64, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1},
      {8'd1,  1'b0, 1'b0, 2'b00, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_start = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          rx_end = 1'b0;
   logic          rx_crc_err = 1'b0;
   logic          hs_stb;
   logic [1:0]    hs_code;
   logic          buf_release = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          irq_shared, irq_a, irq_b;

   int errors = 0;
   int checks = 0;
   int idle_bad = 0;

   always #2.5 clk = ~clk;

   usb_oep_rx #(.PKT_BYTES(PKT), .DATA_W(8), .HS_LATENCY(HS_LAT), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_end(rx_end), .rx_crc_err(rx_crc_err),
      .hs_stb(hs_stb), .hs_code(hs_code), .buf_release(buf_release),
      .rd_addr(rd_addr), .rd_data(rd_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_shared(irq_shared),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_byte(input int a, output logic [7:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic release_buf();
      @(negedge clk);
      buf_release = 1'b1;
      @(negedge clk);
      buf_release = 1'b0;
   endtask

   // sends one packet; records strobe count, last code and the cycle it appeared
   task automatic send_pkt(input int n, input bit crc, input logic [7:0] base, input bit clr_same,
                           output logic [1:0] code, output int stbs, output int when);
      @(negedge clk);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_byte  = base + 8'(i);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_end = 1'b1;
      rx_crc_err = crc;
      if (clr_same) begin
         reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
      end
      @(negedge clk);
      rx_end = 1'b0; rx_crc_err = 1'b0; reg_wr = 1'b0;
      code = 2'b00; stbs = 0; when = 0; idle_bad = 0;
      for (int k = 1; k <= 4; k++) begin
         if (hs_stb) begin
            stbs++; code = hs_code; when = k;
         end else if (hs_code != 2'b00) begin
            idle_bad++;
         end
         if (k < 4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [13:0] ent;
      logic [7:0]  d;
      logic [7:0]  base;
      logic [7:0]  last_base;
      logic [1:0]  code;
      int          stbs, when;
      logic        full_m;
      string       tag;

      full_m = 1'b0;
      last_base = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(2'd0, d); chk("R1 status after reset", d, 8'h00);
      rd_reg(2'd1, d); chk("R1 enables after reset", d, 8'h00);
      rd_reg(2'd2, d); chk("R1 routes after reset", d, 8'h00);
      chk("R1 irq lines after reset", {irq_shared, irq_a, irq_b}, 3'b000);
      chk("R1 handshake idle after reset", {hs_stb, hs_code}, 3'b000);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         ent = VEC[v];
         wr_reg(2'd0, 8'h00);
         if (ent[5]) begin
            release_buf();
            full_m = 1'b0;
         end
         base = 8'(v * 16 + 3);
         send_pkt(int'(ent[13:6]), ent[4], base, 1'b0, code, stbs, when);
         tag = (ent[3:2] == 2'b01) ? "R2 accepted packet" :
               (ent[3:2] == 2'b10) ? "R3 refused packet"  : "R4 malformed packet";
         chk({tag, " strobe count"}, stbs, (ent[3:2] == 2'b00) ? 0 : 1);
         chk({tag, " code"}, code, ent[3:2]);
         if (ent[3:2] != 2'b00) chk("R2 handshake latency", when, HS_LAT);
         chk("R11 idle code zero", idle_bad, 0);
         if (ent[3:2] == 2'b01) begin
            full_m = 1'b1;
            last_base = base;
         end
         rd_reg(2'd0, d);
         chk({tag, " fullerr flag"}, d[0], ent[1]);
         chk({tag, " done flag"}, d[1], ent[0]);
         chk("R6 buffer full bit", d[2], full_m);
         if (full_m) begin
            rd_byte(0, d);        chk("R7 byte 0", d, last_base);
            rd_byte(17, d);       chk("R7 byte 17", d, last_base + 8'd17);
            rd_byte(PKT - 1, d);  chk("R7 last byte", d, last_base + 8'(PKT - 1));
         end
      end

      // R5 write-one keeps, write-zero clears, bit 2 read-only (buffer is full here)
      send_pkt(PKT, 1'b0, 8'h40, 1'b0, code, stbs, when);
      chk("R3 NAK on full buffer", code, 2'b10);
      wr_reg(2'd0, 8'hFF);
      rd_reg(2'd0, d); chk("R5 write ones keeps flags", d, 8'h05);
      wr_reg(2'd0, 8'h04);
      rd_reg(2'd0, d); chk("R5 write zero clears fullerr", d, 8'h04);
      rd_byte(5, d); chk("R3 refused data left buffer intact", d, last_base + 8'd5);

      // R8 / R9 routing of the full-error event
      send_pkt(PKT, 1'b0, 8'h50, 1'b0, code, stbs, when);
      chk("R9 enables off gives quiet lines", {irq_shared, irq_a, irq_b}, 3'b000);
      wr_reg(2'd1, 8'h01);
      chk("R8 default route to shared", {irq_shared, irq_a, irq_b}, 3'b100);
      wr_reg(2'd2, 8'h01);
      chk("R8 route 01 to line A", {irq_shared, irq_a, irq_b}, 3'b010);
      wr_reg(2'd2, 8'h02);
      chk("R8 route 10 to line B", {irq_shared, irq_a, irq_b}, 3'b001);
      wr_reg(2'd2, 8'h03);
      chk("R8 route 11 to shared", {irq_shared, irq_a, irq_b}, 3'b100);

      // both events on separate lines
      release_buf();
      send_pkt(PKT, 1'b0, 8'h60, 1'b0, code, stbs, when);
      chk("R6 retry after release gets ACK", code, 2'b01);
      wr_reg(2'd2, 8'h06);
      wr_reg(2'd1, 8'h03);
      rd_reg(2'd2, d); chk("R8 route register readback", d, 8'h06);
      chk("R9 done on A, fullerr on B", {irq_shared, irq_a, irq_b}, 3'b011);
      wr_reg(2'd1, 8'h02);
      chk("R9 enable masks fullerr", {irq_shared, irq_a, irq_b}, 3'b010);
      wr_reg(2'd0, 8'h02);
      rd_reg(2'd0, d); chk("R5 selective clear keeps done", d, 8'h06);

      // R10 set and clear in the same cycle
      wr_reg(2'd0, 8'h00);
      release_buf();
      send_pkt(PKT, 1'b0, 8'h70, 1'b1, code, stbs, when);
      rd_reg(2'd0, d); chk("R10 done set beats clear", d, 8'h06);
      send_pkt(PKT, 1'b0, 8'h80, 1'b1, code, stbs, when);
      chk("R3 NAK during clear", code, 2'b10);
      rd_reg(2'd0, d); chk("R10 fullerr set beats clear", d, 8'h05);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule